// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block makes the control-flow decision for a five-stage pipeline while the branch sits in the decode stage. It compares two register operands for equal and not-equal branches, forms the PC-relative destination, and drives the select of the next-PC mux. The fetch stage always fetches the sequential instruction. If the branch turns out taken, the block can either discard that instruction or, in delay-slot mode, let it run.

Unconditional jumps use the same redirect path without any operand compare. Decode-stage forwarding is not assumed. When an operand register is still being produced by an instruction further down the pipe, the branch is held in decode until the register file holds the value. The block is purely combinational and sits between the IF/ID register, the register file read ports and the PC mux.

Top module: `br_decode_resolve`

## Requirements
- R1: With `br_kind_i`=1 (branch-if-equal) and a valid, unstalled decode slot, `npc_sel_o` is 1 (target) when the operands are equal and 0 (sequential) when they differ.
- R2: With `br_kind_i`=2 (branch-if-not-equal), `npc_sel_o` is 1 when the operands differ and 0 when they are equal.
- R3: `target_o` always equals `pc_plus4_i` plus the sign-extended offset shifted left by two, modulo 2^32. This covers negative offsets and wrap-around (for example 44 + 7*4 = 72).
- R4: When delay-slot mode is off (`slot_mode_i`=0), a taken branch or jump raises `flush_o` in the same cycle, which marks the instruction fetched behind it as a bubble. A not-taken branch leaves `flush_o` at 0 and `npc_sel_o` at 0, so it costs no penalty.
- R5: When delay-slot mode is on (`slot_mode_i`=1), `flush_o` is never raised. Taken branches and jumps still redirect with `npc_sel_o`=1.
- R6: `br_kind_i`=3 (jump) always redirects (`npc_sel_o`=1). It ignores the operand values and never stalls.
- R7: A conditional branch whose source register index (`src_a_idx_i` or `src_b_idx_i`) equals the destination of an in-flight producer raises `stall_o`. It sets `npc_sel_o` to 2 (hold) and keeps `flush_o` at 0. Producer 0 is the EX stage and producer 1 is the MEM stage; each producer has a write-enable bit and a register index.
- R8: A producer whose write-enable is 0, or whose destination index is register 0, never causes a stall.
- R9: When `id_valid_i` is 0, or `br_kind_i`=0 (no branch), the outputs are `npc_sel_o`=0, `flush_o`=0 and `stall_o`=0.
- R10: The equality compare covers all 32 bits, so operands that differ only in bit 31 count as unequal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slot_mode_i | input | 1 | 1 selects delay-slot mode; 0 selects predict-not-taken with flush |
| id_valid_i | input | 1 | The IF/ID register holds a real instruction |
| br_kind_i | input | 2 | 0 none, 1 equal, 2 not-equal, 3 jump |
| src_a_val_i | input | 32 | First operand value from the register file |
| src_b_val_i | input | 32 | Second operand value from the register file |
| src_a_idx_i | input | 5 | First operand register index |
| src_b_idx_i | input | 5 | Second operand register index |
| prod_wen_i | input | 2 | Write enables of the producers (bit 0 EX, bit 1 MEM) |
| prod_rd_i | input | 2x5 | Destination indices of the producers |
| ofs_i | input | 32 | Sign-extended word offset |
| pc_plus4_i | input | 32 | Address of the instruction after the branch |
| npc_sel_o | output | 2 | Next-PC select: 0 sequential, 1 target, 2 hold |
| target_o | output | 32 | Branch or jump destination |
| flush_o | output | 1 | Turn the IF/ID contents into a bubble |
| stall_o | output | 1 | Hold PC and IF/ID because an operand is not ready |

## Verification
Equal and not-equal branches are driven with operand pairs that match, differ in low bits, and differ only in the top bit. These patterns separate a correct compare from a truncated or inverted one. The same taken branch is repeated in both slot modes, so the flush decision is checked apart from the redirect. Producer patterns hit each stage on each operand and then repeat with register 0 or write-enable off, which tells a real dependency from a false one. Positive, negative and wrapping offsets check the address arithmetic.

// File: rtl/br_pkg.sv
package br_pkg;
   typedef enum logic [1:0] {
      BK_NONE = 2'd0,
      BK_EQ   = 2'd1,
      BK_NE   = 2'd2,
      BK_JUMP = 2'd3
   } br_kind_e;

   typedef enum logic [1:0] {
      NPC_SEQ    = 2'd0,
      NPC_TARGET = 2'd1,
      NPC_HOLD   = 2'd2
   } npc_sel_e;
endpackage

// File: rtl/br_operand_cmp.sv
module br_operand_cmp #(
   parameter int XLEN    = 32,
   parameter int SLICE_W = 8
) (
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   output logic            eq_o
);
   localparam int NSL = XLEN / SLICE_W;

   generate
      if (SLICE_W < 1 || (XLEN % SLICE_W) != 0) begin : g_bad_slice
         $error("br_operand_cmp: XLEN must be a multiple of SLICE_W");
      end
      if (SLICE_W >= XLEN) begin : g_flat
         assign eq_o = (a_i == b_i);
      end else begin : g_sliced
         logic [NSL-1:0] sl_eq;
         for (genvar s = 0; s < NSL; s++) begin : g_sl
            assign sl_eq[s] = (a_i[s*SLICE_W +: SLICE_W] == b_i[s*SLICE_W +: SLICE_W]);
         end
         assign eq_o = &sl_eq;
      end
   endgenerate
endmodule

// File: rtl/br_target_gen.sv
module br_target_gen #(
   parameter int XLEN      = 32,
   parameter int OFS_SHIFT = 2
) (
   input  logic [XLEN-1:0] pc_plus4_i,
   input  logic [XLEN-1:0] ofs_i,
   output logic [XLEN-1:0] target_o
);
   generate
      if (OFS_SHIFT < 0 || OFS_SHIFT >= XLEN) begin : g_bad_shift
         $error("br_target_gen: OFS_SHIFT out of range");
      end
   endgenerate

   logic [XLEN-1:0] ofs_bytes;
   assign ofs_bytes = ofs_i << OFS_SHIFT;
   assign target_o  = pc_plus4_i + ofs_bytes;
endmodule

// File: rtl/br_src_hazard.sv
module br_src_hazard #(
   parameter int REGW          = 5,
   parameter int NPROD         = 2,
   parameter bit ZERO_HARDWIRE = 1'b1
) (
   input  logic [REGW-1:0]            src_a_idx_i,
   input  logic [REGW-1:0]            src_b_idx_i,
   input  logic [NPROD-1:0]           prod_wen_i,
   input  logic [NPROD-1:0][REGW-1:0] prod_rd_i,
   output logic                       hit_o
);
   generate
      if (NPROD < 1) begin : g_bad_nprod
         $error("br_src_hazard: NPROD must be at least 1");
      end
   endgenerate

   logic [NPROD-1:0] hit_vec;

   generate
      for (genvar p = 0; p < NPROD; p++) begin : g_prod
         logic live;
         if (ZERO_HARDWIRE) begin : g_z
            assign live = prod_wen_i[p] && (prod_rd_i[p] != '0);
         end else begin : g_nz
            assign live = prod_wen_i[p];
         end
         assign hit_vec[p] = live &&
                             ((prod_rd_i[p] == src_a_idx_i) || (prod_rd_i[p] == src_b_idx_i));
      end
   endgenerate

   assign hit_o = |hit_vec;
endmodule

// File: rtl/br_decode_resolve.sv
module br_decode_resolve #(
   parameter int XLEN      = 32,
   parameter int REGW      = 5,
   parameter int NPROD     = 2,
   parameter int OFS_SHIFT = 2,
   parameter int CMP_SLICE = 8
) (
   input  logic                       slot_mode_i,
   input  logic                       id_valid_i,
   input  logic [1:0]                 br_kind_i,
   input  logic [XLEN-1:0]            src_a_val_i,
   input  logic [XLEN-1:0]            src_b_val_i,
   input  logic [REGW-1:0]            src_a_idx_i,
   input  logic [REGW-1:0]            src_b_idx_i,
   input  logic [NPROD-1:0]           prod_wen_i,
   input  logic [NPROD-1:0][REGW-1:0] prod_rd_i,
   input  logic [XLEN-1:0]            ofs_i,
   input  logic [XLEN-1:0]            pc_plus4_i,
   output logic [1:0]                 npc_sel_o,
   output logic [XLEN-1:0]            target_o,
   output logic                       flush_o,
   output logic                       stall_o
);
   import br_pkg::*;

   br_kind_e kind;
   logic     ops_eq;
   logic     dep_hit;
   logic     is_cond;
   logic     cond_met;
   logic     redirect;

   assign kind = br_kind_e'(br_kind_i);

   br_operand_cmp #(.XLEN(XLEN), .SLICE_W(CMP_SLICE)) cmp_i (
      .a_i  (src_a_val_i),
      .b_i  (src_b_val_i),
      .eq_o (ops_eq)
   );

   br_target_gen #(.XLEN(XLEN), .OFS_SHIFT(OFS_SHIFT)) tgt_i (
      .pc_plus4_i (pc_plus4_i),
      .ofs_i      (ofs_i),
      .target_o   (target_o)
   );

   br_src_hazard #(.REGW(REGW), .NPROD(NPROD), .ZERO_HARDWIRE(1'b1)) haz_i (
      .src_a_idx_i (src_a_idx_i),
      .src_b_idx_i (src_b_idx_i),
      .prod_wen_i  (prod_wen_i),
      .prod_rd_i   (prod_rd_i),
      .hit_o       (dep_hit)
   );

   always_comb begin
      is_cond  = (kind == BK_EQ) || (kind == BK_NE);
      cond_met = (kind == BK_EQ) ? ops_eq : !ops_eq;
      stall_o  = id_valid_i && is_cond && dep_hit;
      redirect = id_valid_i && !stall_o &&
                 ((kind == BK_JUMP) || (is_cond && cond_met));
      flush_o  = redirect && !slot_mode_i;
      if (stall_o)       npc_sel_o = NPC_HOLD;
      else if (redirect) npc_sel_o = NPC_TARGET;
      else               npc_sel_o = NPC_SEQ;
   end
endmodule

// File: rtl/br_decode_resolve_chk.sv
module br_decode_resolve_chk #(
   parameter int XLEN  = 32,
   parameter int REGW  = 5,
   parameter int NPROD = 2
) (
   input logic                       slot_mode_i,
   input logic                       id_valid_i,
   input logic [1:0]                 br_kind_i,
   input logic [XLEN-1:0]            src_a_val_i,
   input logic [XLEN-1:0]            src_b_val_i,
   input logic [NPROD-1:0]           prod_wen_i,
   input logic [1:0]                 npc_sel_o,
   input logic                       flush_o,
   input logic                       stall_o
);
   always_comb begin
      // R5
      slot_no_flush_chk: assert (!(slot_mode_i && flush_o))
         else $error("flush raised in delay-slot mode");
      // R4
      flush_redirects_chk: assert (!flush_o || (npc_sel_o == 2'd1))
         else $error("flush without redirect");
      // R7
      stall_holds_chk: assert (!stall_o || ((npc_sel_o == 2'd2) && !flush_o))
         else $error("stall without hold or with flush");
      // R9
      idle_quiet_chk: assert (id_valid_i || ((npc_sel_o == 2'd0) && !flush_o && !stall_o))
         else $error("empty decode slot acted");
      // R6
      jump_redirect_chk: assert (!(id_valid_i && br_kind_i == 2'd3) || (npc_sel_o == 2'd1 && !stall_o))
         else $error("jump did not redirect");
      // R8
      no_writer_no_stall_chk: assert ((prod_wen_i != '0) || !stall_o)
         else $error("stall with no producer writing");
      // R1
      beq_equal_chk: assert (!(id_valid_i && !stall_o && br_kind_i == 2'd1 && src_a_val_i == src_b_val_i)
                             || npc_sel_o == 2'd1)
         else $error("equal branch on equal operands not taken");
   end
endmodule

bind br_decode_resolve br_decode_resolve_chk #(.XLEN(XLEN), .REGW(REGW), .NPROD(NPROD)) chk_i (
   .slot_mode_i (slot_mode_i),
   .id_valid_i  (id_valid_i),
   .br_kind_i   (br_kind_i),
   .src_a_val_i (src_a_val_i),
   .src_b_val_i (src_b_val_i),
   .prod_wen_i  (prod_wen_i),
   .npc_sel_o   (npc_sel_o),
   .flush_o     (flush_o),
   .stall_o     (stall_o)
);

// File: tb/br_decode_resolve_tb_top.sv
module br_decode_resolve_tb_top;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic            slot_mode, id_valid;
   logic [1:0]      kind;
   logic [31:0]     a_val, b_val, ofs, pc4;
   logic [4:0]      a_idx, b_idx;
   logic [1:0]      pwen;
   logic [1:0][4:0] prd;
   logic [1:0]      npc_sel;
   logic [31:0]     target;
   logic            flush, stall;

   br_decode_resolve dut_i (
      .slot_mode_i (slot_mode), .id_valid_i (id_valid), .br_kind_i (kind),
      .src_a_val_i (a_val), .src_b_val_i (b_val),
      .src_a_idx_i (a_idx), .src_b_idx_i (b_idx),
      .prod_wen_i (pwen), .prod_rd_i (prd),
      .ofs_i (ofs), .pc_plus4_i (pc4),
      .npc_sel_o (npc_sel), .target_o (target),
      .flush_o (flush), .stall_o (stall)
   );

   typedef struct {
      logic [1:0]  sel;
      logic [31:0] tgt;
      logic        fl;
      logic        st;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   fails  = 0;
   bit   done   = 1'b0;

   task automatic apply(input string tag, input bit mode, input bit vld, input logic [1:0] k,
                        input logic [31:0] av, input logic [31:0] bv,
                        input logic [4:0] ai, input logic [4:0] bi,
                        input logic [1:0] we, input logic [4:0] rd_ex, input logic [4:0] rd_mem,
                        input logic [31:0] o, input logic [31:0] p);
      exp_t e;
      bit dep, take;
      @(posedge clk); #1;
      slot_mode = mode; id_valid = vld; kind = k; a_val = av; b_val = bv;
      a_idx = ai; b_idx = bi; pwen = we; prd[0] = rd_ex; prd[1] = rd_mem; ofs = o; pc4 = p;
      dep  = (we[0] && rd_ex  != 5'd0 && (rd_ex  == ai || rd_ex  == bi)) ||
             (we[1] && rd_mem != 5'd0 && (rd_mem == ai || rd_mem == bi));
      e.st = vld && (k == 2'd1 || k == 2'd2) && dep;
      take = vld && !e.st && ((k == 2'd3) || (k == 2'd1 && av == bv) || (k == 2'd2 && av != bv));
      e.sel = e.st ? 2'd2 : (take ? 2'd1 : 2'd0);
      e.fl  = take && !mode;
      e.tgt = p + (o * 32'd4);
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            checks++;
            if (npc_sel !== e.sel || target !== e.tgt || flush !== e.fl || stall !== e.st) begin
               fails++;
               $display("FAIL %s: sel=%0d tgt=%h fl=%b st=%b expected sel=%0d tgt=%h fl=%b st=%b",
                        e.tag, npc_sel, target, flush, stall, e.sel, e.tgt, e.fl, e.st);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : driver
      slot_mode = 0; id_valid = 0; kind = 0; a_val = 0; b_val = 0; a_idx = 0; b_idx = 0;
      pwen = 0; prd = '0; ofs = 0; pc4 = 0;
      // R9 idle after start-up
      apply("R9 idle", 0, 1, 2'd0, 32'd5, 32'd5, 5'd1, 5'd2, 2'b00, 5'd0, 5'd0, 32'd7, 32'd44);
      // R1 R3 R4 equal taken, 44 + 7*4 = 72, flush
      apply("R1 R3 R4 beq taken", 0, 1, 2'd1, 32'd9, 32'd9, 5'd1, 5'd2, 2'b00, 5'd0, 5'd0, 32'd7, 32'd44);
      // R1 R4 not taken, no penalty
      apply("R1 R4 beq not taken", 0, 1, 2'd1, 32'd9, 32'd8, 5'd1, 5'd2, 2'b00, 5'd0, 5'd0, 32'd7, 32'd44);
      // R2 not-equal taken / not taken
      apply("R2 bne taken", 0, 1, 2'd2, 32'd3, 32'd4, 5'd3, 5'd4, 2'b00, 5'd0, 5'd0, 32'd2, 32'd200);
      apply("R2 bne not taken", 0, 1, 2'd2, 32'd4, 32'd4, 5'd3, 5'd4, 2'b00, 5'd0, 5'd0, 32'd2, 32'd200);
      // R5 delay-slot mode: redirect without flush
      apply("R5 slot beq", 1, 1, 2'd1, 32'd1, 32'd1, 5'd1, 5'd2, 2'b00, 5'd0, 5'd0, 32'd7, 32'd44);
      apply("R5 slot bne", 1, 1, 2'd2, 32'd1, 32'd2, 5'd1, 5'd2, 2'b00, 5'd0, 5'd0, 32'd1, 32'd8);
      // R3 negative offset and wrap
      apply("R3 negative ofs", 0, 1, 2'd1, 32'd0, 32'd0, 5'd1, 5'd2, 2'b00, 5'd0, 5'd0, -32'sd3, 32'd100);
      apply("R3 wrap", 0, 1, 2'd3, 32'd0, 32'd1, 5'd1, 5'd2, 2'b00, 5'd0, 5'd0, 32'd2, 32'hFFFF_FFFC);
      // R10 differ only in bit 31
      apply("R10 beq msb", 0, 1, 2'd1, 32'h8000_0000, 32'd0, 5'd1, 5'd2, 2'b00, 5'd0, 5'd0, 32'd1, 32'd16);
      apply("R10 bne msb", 0, 1, 2'd2, 32'h8000_0001, 32'd1, 5'd1, 5'd2, 2'b00, 5'd0, 5'd0, 32'd1, 32'd16);
      // R6 jump ignores operands and hazards
      apply("R6 jump hazard", 0, 1, 2'd3, 32'd1, 32'd2, 5'd6, 5'd7, 2'b11, 5'd6, 5'd7, 32'd5, 32'd20);
      apply("R6 jump slot", 1, 1, 2'd3, 32'd1, 32'd2, 5'd6, 5'd7, 2'b00, 5'd0, 5'd0, 32'd5, 32'd20);
      // R7 EX producer on operand A, MEM producer on operand B
      apply("R7 ex dep", 0, 1, 2'd1, 32'd1, 32'd1, 5'd8, 5'd9, 2'b01, 5'd8, 5'd0, 32'd5, 32'd20);
      apply("R7 mem dep", 0, 1, 2'd2, 32'd1, 32'd2, 5'd8, 5'd9, 2'b10, 5'd0, 5'd9, 32'd5, 32'd20);
      // R8 register 0 and disabled writers
      apply("R8 zero reg", 0, 1, 2'd1, 32'd1, 32'd1, 5'd0, 5'd9, 2'b11, 5'd0, 5'd0, 32'd5, 32'd20);
      apply("R8 wen off", 0, 1, 2'd1, 32'd1, 32'd1, 5'd8, 5'd9, 2'b00, 5'd8, 5'd9, 32'd5, 32'd20);
      // R9 invalid decode slot
      apply("R9 invalid", 0, 0, 2'd1, 32'd1, 32'd1, 5'd8, 5'd9, 2'b01, 5'd8, 5'd0, 32'd5, 32'd20);
      while (exp_q.size() > 0) @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule